// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system use an external asynchronous static RAM of 8192 eight-bit words. The system side offers one access at a time through a request/ready handshake: the requester presents an address, a direction flag and, for a write, a data byte. It then waits for `user_ready` to return before it presents the next access. A read returns its byte on `user_rdata` together with a single-cycle `user_rvalid` pulse.

On the memory side the controller drives the address and three active-low strobes: chip select, output enable and write enable. It handles the bidirectional data pins through a separate output value, an output-enable and an input value. Each phase of an access is held for a whole number of clock cycles. The count is derived at elaboration from the clock period and the memory's minimum access, pulse, setup and hold times, so slower or faster parts are handled by changing parameters only. Between accesses the memory is always deselected.

Top module: `async_sram_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `sram_cs_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe` is 0, `user_rvalid` is 0 and `user_ready` is 1.
- R2: `user_ready` is 1 only when no access is in progress. An access starts on a rising clock edge where `user_req` and `user_ready` are both 1. The address, direction and write byte are taken at that edge, and later changes to those inputs have no effect on that access.
- R3: While the controller is idle, `sram_cs_n` is 1 and `sram_dq_oe` is 0.
- R4: A read (`user_wr`=0) holds `sram_cs_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for exactly RD cycles after the accepting edge. RD is the largest phase length of the address access, select access, output-enable access and read cycle times. The data pins are sampled on the edge that ends those RD cycles. That byte appears on `user_rdata` with `user_rvalid`=1 for exactly one cycle.
- R5: In the cycle where `user_rvalid` is 1, `sram_cs_n` and `sram_oe_n` are already 1. `user_ready` returns one cycle later, so a read occupies RD+1 cycles.
- R6: A write (`user_wr`=1) first holds `sram_cs_n`=0 with `sram_we_n`=1 for SU cycles, where SU is the phase length of the address setup time. It then holds `sram_we_n`=0 for WP cycles, driving the stored byte (`sram_dq_oe`=1) during that time. `sram_oe_n` stays 1 throughout the write.
- R7: WP is the largest of: the phase lengths of the write pulse width and the data setup time; the phase length of the select-to-write-end time minus SU; and the phase length of the write cycle time minus SU and HD. WP is never less than 1.
- R8: After `sram_we_n` rises, `sram_cs_n` stays 0 and the byte stays driven for HD cycles. HD is the larger of the phase lengths of the address hold and data hold times, so HD is at least 1. The controller then goes idle, and a write occupies SU+WP+HD cycles.
- R9: The phase length of a time t is ceil(t / `CLK_PERIOD_NS`), and it is never less than one cycle.
- R10: A synchronous reset asserted in the middle of an access sets all three strobes to 1, releases the data pins and makes `user_ready` 1 on the next edge.
- R11: `sram_we_n` and `sram_oe_n` are never 0 together, and `sram_dq_oe` is never 1 while `sram_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| user_req | input | 1 | Access request |
| user_ready | output | 1 | Controller idle, able to accept a request |
| user_wr | input | 1 | 1 = write, 0 = read |
| user_addr | input | ADDR_W | Word address |
| user_wdata | input | DATA_W | Write byte |
| user_rdata | output | DATA_W | Read byte, valid with `user_rvalid` |
| user_rvalid | output | 1 | One-cycle read completion pulse |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_o | output | DATA_W | Value driven onto the data pins |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_i | input | DATA_W | Value read from the data pins |

## Verification
A wrong phase count moves a port-visible edge in the same access. The read pulse arrives a cycle early or late, the write strobe is a cycle too short or too long, or ready returns off schedule. A device model that returns corrupt data until the strobes have been stable for RD cycles turns an early sample into a wrong byte on `user_rdata` at once. A lost or misdirected write only shows on a later read of the same address, so random traffic reuses a small pool of addresses to keep that gap short. Strobe overlap, bus drive during a read and a selected idle memory are checked on every cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_RD_ACC   = 3'd1,
      ST_RD_DONE  = 3'd2,
      ST_WR_SU    = 3'd3,
      ST_WR_PULSE = 3'd4,
      ST_WR_HOLD  = 3'd5
   } sram_state_e;

   // Clock cycles needed to cover a minimum time, never less than one.
   function automatic int phase_cycles(input int t_ns, input int period_ns);
      int c;
      c = (t_ns + period_ns - 1) / period_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
   parameter int MAX_LEN = 4,
   parameter int CNT_W   = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   generate
      if (MAX_LEN <= 1) begin : g_single
         // Every phase lasts one cycle: no counter is needed.
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst, load, load_val};
         assign done = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst)                  cnt_q <= '0;
            else if (load)            cnt_q <= load_val;
            else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
         end

         assign done = (cnt_q == '0);

         // A loaded count never exceeds the longest phase.
         assert_load_range_R9: assert property (@(posedge clk) disable iff (rst)
            load |-> (int'(load_val) < MAX_LEN));
      end
   endgenerate

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= in_addr;
         wdata_q <= in_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)          rdata_q <= '0;
      else if (capture) rdata_q <= dq_in;
   end

   // Address and write byte stay put for the whole access.
   assert_addr_held_R2: assert property (@(posedge clk) disable iff (rst)
      (!accept && !$past(accept) && !$past(rst)) |-> $stable(addr_q));

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int RD_CYC = 1,
   parameter int SU_CYC = 1,
   parameter int WP_CYC = 1,
   parameter int HD_CYC = 1,
   parameter int CNT_W  = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req,
   input  logic             wr,
   input  logic             tmr_done,
   output logic             ready,
   output logic             accept,
   output logic             capture,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             cs_n,
   output logic             oe_n,
   output logic             we_n,
   output logic             dq_oe,
   output logic             rvalid
);

   localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] SU_LD = CNT_W'(SU_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] HD_LD = CNT_W'(HD_CYC - 1);

   sram_state_e state_q, state_d;

   assign ready  = (state_q == ST_IDLE);
   assign accept = ready && req;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req) begin
               tmr_load = 1'b1;
               if (wr) begin
                  state_d = ST_WR_SU;
                  tmr_val = SU_LD;
               end else begin
                  state_d = ST_RD_ACC;
                  tmr_val = RD_LD;
               end
            end
         end
         ST_RD_ACC: begin
            if (tmr_done) begin
               capture = 1'b1;
               state_d = ST_RD_DONE;
            end
         end
         ST_RD_DONE: state_d = ST_IDLE;
         ST_WR_SU: begin
            if (tmr_done) begin
               state_d  = ST_WR_PULSE;
               tmr_load = 1'b1;
               tmr_val  = WP_LD;
            end
         end
         ST_WR_PULSE: begin
            if (tmr_done) begin
               state_d  = ST_WR_HOLD;
               tmr_load = 1'b1;
               tmr_val  = HD_LD;
            end
         end
         ST_WR_HOLD: begin
            if (tmr_done) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // Strobes are registered from the next state so the pins never glitch.
   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cs_n    <= 1'b1;
         oe_n    <= 1'b1;
         we_n    <= 1'b1;
         dq_oe   <= 1'b0;
         rvalid  <= 1'b0;
      end else begin
         state_q <= state_d;
         cs_n    <= !(state_d inside {ST_RD_ACC, ST_WR_SU, ST_WR_PULSE, ST_WR_HOLD});
         oe_n    <= (state_d != ST_RD_ACC);
         we_n    <= (state_d != ST_WR_PULSE);
         dq_oe   <= (state_d inside {ST_WR_PULSE, ST_WR_HOLD});
         rvalid  <= (state_d == ST_RD_DONE);
      end
   end

   assert_idle_deselect_R3: assert property (@(posedge clk) disable iff (rst)
      ready |-> (cs_n && !dq_oe));

   assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
      !(!we_n && !oe_n));

   assert_no_drive_on_read_R11: assert property (@(posedge clk) disable iff (rst)
      dq_oe |-> oe_n);

   assert_write_strobe_R6: assert property (@(posedge clk) disable iff (rst)
      !we_n |-> (!cs_n && dq_oe && oe_n));

   assert_read_strobe_R4: assert property (@(posedge clk) disable iff (rst)
      !oe_n |-> (!cs_n && we_n));

   assert_rvalid_single_R4: assert property (@(posedge clk) disable iff (rst)
      rvalid |=> !rvalid);

   assert_rvalid_released_R5: assert property (@(posedge clk) disable iff (rst)
      rvalid |-> (cs_n && oe_n));

   assert_hold_drive_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(we_n)) |-> (dq_oe && !cs_n));

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 13,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 20,
   parameter int T_AA_NS       = 10,
   parameter int T_ACE_NS      = 10,
   parameter int T_DOE_NS      = 5,
   parameter int T_RC_NS       = 10,
   parameter int T_SA_NS       = 0,
   parameter int T_PWE_NS      = 8,
   parameter int T_SD_NS       = 8,
   parameter int T_SCE_NS      = 9,
   parameter int T_WC_NS       = 10,
   parameter int T_HA_NS       = 0,
   parameter int T_HD_NS       = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              user_req,
   output logic              user_ready,
   input  logic              user_wr,
   input  logic [ADDR_W-1:0] user_addr,
   input  logic [DATA_W-1:0] user_wdata,
   output logic [DATA_W-1:0] user_rdata,
   output logic              user_rvalid,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_cs_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   output logic [DATA_W-1:0] sram_dq_o,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_i
);

   localparam int RD_CYC = imax(imax(phase_cycles(T_AA_NS, CLK_PERIOD_NS),
                                     phase_cycles(T_ACE_NS, CLK_PERIOD_NS)),
                                imax(phase_cycles(T_DOE_NS, CLK_PERIOD_NS),
                                     phase_cycles(T_RC_NS, CLK_PERIOD_NS)));
   localparam int SU_CYC = phase_cycles(T_SA_NS, CLK_PERIOD_NS);
   localparam int HD_CYC = imax(phase_cycles(T_HA_NS, CLK_PERIOD_NS),
                                phase_cycles(T_HD_NS, CLK_PERIOD_NS));
   localparam int WP_RAW = imax(imax(phase_cycles(T_PWE_NS, CLK_PERIOD_NS),
                                     phase_cycles(T_SD_NS, CLK_PERIOD_NS)),
                                imax(phase_cycles(T_SCE_NS, CLK_PERIOD_NS) - SU_CYC,
                                     phase_cycles(T_WC_NS, CLK_PERIOD_NS) - SU_CYC - HD_CYC));
   localparam int WP_CYC  = imax(WP_RAW, 1);
   localparam int MAX_LEN = imax(imax(RD_CYC, SU_CYC), imax(WP_CYC, HD_CYC));
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("async_sram_ctrl: address and data widths must be positive");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("async_sram_ctrl: clock period must be at least 1 ns");
      end
      if (T_AA_NS < 0 || T_ACE_NS < 0 || T_DOE_NS < 0 || T_RC_NS < 0 ||
          T_SA_NS < 0 || T_PWE_NS < 0 || T_SD_NS < 0 || T_SCE_NS < 0 ||
          T_WC_NS < 0 || T_HA_NS < 0 || T_HD_NS < 0) begin : g_bad_time
         $error("async_sram_ctrl: timing parameters must not be negative");
      end
   endgenerate

   logic             accept, capture, tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_val;

   sram_ctrl_timer #(
      .MAX_LEN (MAX_LEN),
      .CNT_W   (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   sram_ctrl_fsm #(
      .RD_CYC (RD_CYC),
      .SU_CYC (SU_CYC),
      .WP_CYC (WP_CYC),
      .HD_CYC (HD_CYC),
      .CNT_W  (CNT_W)
   ) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .req      (user_req),
      .wr       (user_wr),
      .tmr_done (tmr_done),
      .ready    (user_ready),
      .accept   (accept),
      .capture  (capture),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val),
      .cs_n     (sram_cs_n),
      .oe_n     (sram_oe_n),
      .we_n     (sram_we_n),
      .dq_oe    (sram_dq_oe),
      .rvalid   (user_rvalid)
   );

   sram_ctrl_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_datapath (
      .clk      (clk),
      .rst      (rst),
      .accept   (accept),
      .capture  (capture),
      .in_addr  (user_addr),
      .in_wdata (user_wdata),
      .dq_in    (sram_dq_i),
      .addr_q   (sram_addr),
      .wdata_q  (sram_dq_o),
      .rdata_q  (user_rdata)
   );

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (user_ready && sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_oe));

endmodule

// File: tb/async_sram_ctrl_test.sv
module async_sram_ctrl_test;

   localparam int AW = 13;
   localparam int DW = 8;
   localparam int PER = 20;
   localparam int T_AA = 50, T_ACE = 45, T_DOE = 25, T_RC = 50;
   localparam int T_SA = 0, T_PWE = 30, T_SD = 35, T_SCE = 70, T_WC = 100;
   localparam int T_HA = 0, T_HD = 0;

   function automatic int ph(input int t);
      int c;
      c = (t + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   int rd_exp, su_exp, hd_exp, wp_exp;
   initial begin
      rd_exp = mx(mx(ph(T_AA), ph(T_ACE)), mx(ph(T_DOE), ph(T_RC)));
      su_exp = ph(T_SA);
      hd_exp = mx(ph(T_HA), ph(T_HD));
      wp_exp = mx(1, mx(mx(ph(T_PWE), ph(T_SD)),
                        mx(ph(T_SCE) - su_exp, ph(T_WC) - su_exp - hd_exp)));
   end

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic user_req = 1'b0, user_wr = 1'b0;
   logic [AW-1:0] user_addr = '0;
   logic [DW-1:0] user_wdata = '0;
   logic user_ready, user_rvalid;
   logic [DW-1:0] user_rdata;
   logic [AW-1:0] sram_addr;
   logic sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [DW-1:0] sram_dq_o, sram_dq_i;

   always #(PER/2) clk = ~clk;

   async_sram_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER),
      .T_AA_NS(T_AA), .T_ACE_NS(T_ACE), .T_DOE_NS(T_DOE), .T_RC_NS(T_RC),
      .T_SA_NS(T_SA), .T_PWE_NS(T_PWE), .T_SD_NS(T_SD), .T_SCE_NS(T_SCE),
      .T_WC_NS(T_WC), .T_HA_NS(T_HA), .T_HD_NS(T_HD)
   ) uut (
      .clk(clk), .rst(rst), .user_req(user_req), .user_ready(user_ready),
      .user_wr(user_wr), .user_addr(user_addr), .user_wdata(user_wdata),
      .user_rdata(user_rdata), .user_rvalid(user_rvalid), .sram_addr(sram_addr),
      .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
      .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- device model -----------------
   logic [DW-1:0] mem [int];
   logic [DW-1:0] shadow [int];

   function automatic logic [DW-1:0] init_val(input int a);
      return DW'(a * 7 + 3);
   endfunction
   function automatic logic [DW-1:0] mem_rd(input int a);
      return mem.exists(a) ? mem[a] : init_val(a);
   endfunction
   function automatic logic [DW-1:0] shadow_rd(input int a);
      return shadow.exists(a) ? shadow[a] : init_val(a);
   endfunction

   int  rd_cnt = 0;
   logic [AW-1:0] rd_addr_prev = '0;
   bit  rd_ok = 1'b0;
   int  wp_cnt = 0, su_cnt = 0;
   bit  we_prev = 1'b1, pulse_bad = 1'b0, abort_write = 1'b0;
   logic [AW-1:0] w_addr = '0;
   logic [DW-1:0] w_data = '0;

   // Data only correct once the read strobes have been steady for RD cycles.
   assign sram_dq_i = rd_ok ? mem_rd(int'(sram_addr)) : ~mem_rd(int'(sram_addr));

   always @(negedge clk) begin
      if (!sram_cs_n && !sram_oe_n && sram_we_n) begin
         rd_cnt = (sram_addr == rd_addr_prev && rd_cnt > 0) ? rd_cnt + 1 : 1;
      end else begin
         rd_cnt = 0;
      end
      rd_addr_prev = sram_addr;
      rd_ok = (rd_cnt >= rd_exp);

      if (!rst) begin
         checks++;
         if (user_ready && (!sram_cs_n || sram_dq_oe)) begin
            errors++;
            $display("FAIL R3: idle cs_n=%0b dq_oe=%0b expected 1/0", sram_cs_n, sram_dq_oe);
         end
         checks++;
         if ((!sram_we_n && !sram_oe_n) || (sram_dq_oe && !sram_oe_n)) begin
            errors++;
            $display("FAIL R11: we_n=%0b oe_n=%0b dq_oe=%0b", sram_we_n, sram_oe_n, sram_dq_oe);
         end
      end

      if (sram_cs_n) su_cnt = 0;
      else if (sram_we_n && sram_oe_n && !sram_dq_oe) su_cnt++;

      if (!sram_cs_n && !sram_we_n) begin
         if (we_prev) begin
            if (!abort_write) check(su_cnt == su_exp, "R6 setup cycles", su_cnt, su_exp);
            w_addr = sram_addr;
            w_data = sram_dq_o;
            pulse_bad = 1'b0;
         end
         wp_cnt++;
         if (!sram_dq_oe || !sram_oe_n || sram_dq_o != w_data || sram_addr != w_addr)
            pulse_bad = 1'b1;
      end else if (!we_prev) begin
         if (!abort_write) begin
            check(wp_cnt == wp_exp, "R7 write pulse cycles", wp_cnt, wp_exp);
            check(!pulse_bad, "R6 steady drive during pulse", pulse_bad, 0);
            check(sram_dq_oe && !sram_cs_n, "R8 hold after we rise",
                  {sram_dq_oe, sram_cs_n}, 2'b10);
            if (!pulse_bad) mem[int'(w_addr)] = w_data;
         end
         wp_cnt = 0;
      end
      we_prev = sram_we_n;
   end

   // ---------------- transactions -----------------
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      int n;
      while (!user_ready) @(negedge clk);
      user_req = 1'b1; user_wr = 1'b1; user_addr = a; user_wdata = d;
      @(negedge clk);
      user_req = 1'b0;
      // R2: inputs changed after acceptance must not matter
      user_addr = AW'($urandom); user_wdata = DW'($urandom); user_wr = 1'b0;
      check(!sram_cs_n && sram_we_n && !user_ready, "R6 first write cycle",
            {sram_cs_n, sram_we_n, user_ready}, 3'b010);
      n = 1;
      while (!user_ready && n < 100) begin @(negedge clk); n++; end
      check(n == su_exp + wp_exp + hd_exp + 1, "R8 write length", n,
            su_exp + wp_exp + hd_exp + 1);
      shadow[int'(a)] = d;
   endtask

   task automatic do_read(input logic [AW-1:0] a);
      int n;
      logic [DW-1:0] e;
      while (!user_ready) @(negedge clk);
      user_req = 1'b1; user_wr = 1'b0; user_addr = a;
      @(negedge clk);
      user_req = 1'b0;
      user_addr = AW'($urandom); user_wr = 1'b1;
      check(!sram_cs_n && !sram_oe_n && sram_we_n, "R4 read strobes",
            {sram_cs_n, sram_oe_n, sram_we_n}, 3'b001);
      n = 1;
      while (!user_rvalid && n < 100) begin @(negedge clk); n++; end
      e = shadow_rd(int'(a));
      check(n == rd_exp + 1, "R4 read latency", n, rd_exp + 1);
      check(user_rdata == e, "R4 read data", user_rdata, e);
      check(sram_cs_n && sram_oe_n && !user_ready, "R5 strobes off with rvalid",
            {sram_cs_n, sram_oe_n, user_ready}, 3'b110);
      @(negedge clk);
      check(!user_rvalid && user_ready, "R5 rvalid single and ready back",
            {user_rvalid, user_ready}, 2'b01);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      finish_run();
   end

   logic [AW-1:0] pool [0:15];

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      check(sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_oe && !user_rvalid && user_ready,
            "R1 in reset", {sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, user_rvalid, user_ready},
            6'b111001);
      rst = 1'b0;
      @(negedge clk);
      check(sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_oe && user_ready,
            "R1 after reset", {sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, user_ready}, 5'b11101);
      // R9: derived phase lengths of this instance
      check(rd_exp == 3 && su_exp == 1 && wp_exp == 3 && hd_exp == 1, "R9 phase rule",
            rd_exp * 1000 + su_exp * 100 + wp_exp * 10 + hd_exp, 3131);

      // Directed corners: lowest and highest address, all-ones and zero data
      do_read(13'h0000);
      do_write(13'h0000, 8'hFF);
      do_write(13'h1FFF, 8'h00);
      do_read(13'h0000);
      do_read(13'h1FFF);
      do_write(13'h0AAA, 8'h5A);
      do_write(13'h1555, 8'hA5);
      do_read(13'h0AAA);
      do_read(13'h1555);

      // R10: reset during a write pulse
      while (!user_ready) @(negedge clk);
      user_req = 1'b1; user_wr = 1'b1; user_addr = 13'h0100; user_wdata = 8'h77;
      @(negedge clk);
      user_req = 1'b0;
      repeat (su_exp + 1) @(negedge clk);
      check(!sram_we_n, "R10 inside pulse before reset", sram_we_n, 0);
      abort_write = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      check(sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_oe && user_ready,
            "R10 reset mid write", {sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, user_ready},
            5'b11101);
      rst = 1'b0;
      @(negedge clk);
      abort_write = 1'b0;
      do_write(13'h0100, 8'h33);
      do_read(13'h0100);

      // Random traffic over a small pool so reads follow writes closely
      for (int i = 0; i < 16; i++) pool[i] = AW'($urandom);
      for (int i = 0; i < 120; i++) begin
         logic [AW-1:0] a;
         a = pool[$urandom % 16];
         if ($urandom % 2) do_write(a, DW'($urandom));
         else              do_read(a);
      end
      for (int i = 0; i < 16; i++) do_read(pool[i]);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule